// File: doc/BRIEF.md
# Colour Lookup Table Programming Port

This block holds the colour lookup table of an indexed framebuffer. Each of its 256 entries stores separate 8-bit red, green and blue values. A host programs the table through two write-only registers on a 32-bit bus.

The first register selects the entry to program. The second register takes colour components one at a time: red, then green, then blue. After the blue byte is stored, the selected entry moves forward by one. A host can therefore load a run of consecutive entries with one index write followed by a stream of data writes.

A second, combinational port serves the pixel pipeline. It takes an 8-bit pixel code and returns the 24-bit colour stored for it. Bus reads of the register window return zero and do not change any state.

Top module: `palette_dac`

## Requirements
- R1: After reset, every entry reads back as black (0x000000) on the lookup port, except entry 255, which reads back as white (0xFFFFFF). The selected entry and the component step also reset, so the first data write after reset stores red into entry 0.
- R2: Register decoding uses address bits [3:2] only. The remaining address bits, including bits [1:0], are ignored. Value 0 selects the index register and value 1 selects the colour data register.
- R3: An accepted write to the index register loads bus bits [31:24] as the selected entry and returns the component step to red.
- R4: Successive accepted writes to the data register store bus bits [31:24] as the red, green and blue components of the selected entry, in that order. The lookup port packs a colour as red in [23:16], green in [15:8] and blue in [7:0].
- R5: The write that stores blue advances the selected entry by one, wrapping from 255 to 0, and the component step returns to red.
- R6: Bus reads (valid high, write low) of any register return 0 on the read data port. They change neither the table, the selected entry nor the component step.
- R7: Writes that decode to register 2 or 3 are ignored. They leave the table, the selected entry and the component step unchanged.
- R8: A cycle with valid low has no effect, whatever the write, address and data inputs carry.
- R9: Each accepted data write changes exactly one component of one entry. The lookup port shows the new value after the clock edge that accepts the write, and not before it.
- R10: An index write issued partway through a red/green/blue sequence restarts the sequence at red for the newly selected entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus transaction present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address; bits [3:2] pick the register |
| busWData | input | DATA_W | Write data; the value is taken from bits [31:24] |
| busRData | output | DATA_W | Read data, always zero |
| lookupIdx | input | 8 | Pixel code to translate |
| lookupColor | output | 24 | Colour stored for lookupIdx: {red, green, blue} |

## Verification
The bound checker follows the selected entry and the component step on every cycle. It checks that index writes load and restart, that red, green and blue follow each other, and that the blue write advances and wraps the entry. It also checks that ignored offsets, reads and idle cycles leave both untouched.

Only the bench scenarios can show what lands in the table. These cover the component placement in each entry, the reset contents, and the run through 255 into 0. They also cover the address aliasing and the fact that a new colour shows on the lookup port only after its accepting edge.

// File: rtl/palette_dac_pkg.sv
package palette_dac_pkg;
  localparam int IDX_W   = 8;
  localparam int COMP_W  = 8;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int COLOR_W = 3 * COMP_W;

  typedef enum logic [1:0] {
    COMP_RED   = 2'd0,
    COMP_GREEN = 2'd1,
    COMP_BLUE  = 2'd2
  } comp_e;

  // One table update per cycle at most
  typedef struct packed {
    logic               compWe;
    comp_e              compSel;
    logic [IDX_W-1:0]   entry;
    logic [COMP_W-1:0]  value;
  } ctrlStrobe_t;
endpackage

// File: rtl/palette_dac_ctrl.sv
module palette_dac_ctrl
  import palette_dac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWData,
  output ctrlStrobe_t       strobe,
  output logic [IDX_W-1:0]  curIdx,
  output comp_e             compState
);
  localparam logic [1:0] REG_INDEX = 2'd0;
  localparam logic [1:0] REG_DATA  = 2'd1;

  logic [1:0]        regSel;
  logic              wrAccept;
  logic              wrIndex;
  logic              wrData;
  logic [COMP_W-1:0] wrByte;

  assign regSel   = busAddr[3:2];
  assign wrAccept = busValid && busWrite;
  assign wrIndex  = wrAccept && (regSel == REG_INDEX);
  assign wrData   = wrAccept && (regSel == REG_DATA);
  assign wrByte   = busWData[DATA_W-1 -: COMP_W];

  always_comb begin
    strobe.compWe  = wrData;
    strobe.compSel = compState;
    strobe.entry   = curIdx;
    strobe.value   = wrByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx    <= '0;
      compState <= COMP_RED;
    end else if (wrIndex) begin
      curIdx    <= busWData[DATA_W-1 -: IDX_W];
      compState <= COMP_RED;
    end else if (wrData) begin
      case (compState)
        COMP_RED:   compState <= COMP_GREEN;
        COMP_GREEN: compState <= COMP_BLUE;
        default: begin
          compState <= COMP_RED;
          curIdx    <= curIdx + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/palette_dac_store.sv
module palette_dac_store
  import palette_dac_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [IDX_W-1:0]   lookupIdx,
  output logic [COLOR_W-1:0] lookupColor
);
  logic [COLOR_W-1:0] table_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    localparam logic [COLOR_W-1:0] RST_VAL =
      (e == ENTRIES - 1) ? {COLOR_W{1'b1}} : {COLOR_W{1'b0}};
    logic hit;
    assign hit = strobe.compWe && (strobe.entry == IDX_W'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        table_q[e] <= RST_VAL;
      end else if (hit) begin
        case (strobe.compSel)
          COMP_RED:   table_q[e][3*COMP_W-1 -: COMP_W] <= strobe.value;
          COMP_GREEN: table_q[e][2*COMP_W-1 -: COMP_W] <= strobe.value;
          default:    table_q[e][COMP_W-1   -: COMP_W] <= strobe.value;
        endcase
      end
    end
  end

  assign lookupColor = table_q[lookupIdx];
endmodule

// File: rtl/palette_dac.sv
module palette_dac
  import palette_dac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWData,
  output logic [DATA_W-1:0]  busRData,
  input  logic [IDX_W-1:0]   lookupIdx,
  output logic [COLOR_W-1:0] lookupColor
);
  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] curIdx;
  comp_e            compState;

  palette_dac_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busValid  (busValid),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .busWData  (busWData),
    .strobe    (strobe),
    .curIdx    (curIdx),
    .compState (compState)
  );

  palette_dac_store u_store (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .lookupIdx   (lookupIdx),
    .lookupColor (lookupColor)
  );

  // The register window is write-only
  assign busRData = '0;
endmodule

// File: rtl/palette_dac_chk.sv
module palette_dac_chk
  import palette_dac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWData,
  input logic [IDX_W-1:0]  curIdx,
  input comp_e             compState
);
  logic wrIdx;
  logic wrDat;
  logic wrOther;

  assign wrIdx   = busValid && busWrite && (busAddr[3:2] == 2'd0);
  assign wrDat   = busValid && busWrite && (busAddr[3:2] == 2'd1);
  assign wrOther = busValid && busWrite && busAddr[3];

  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    wrIdx |=> (curIdx == $past(busWData[DATA_W-1 -: IDX_W])) && (compState == COMP_RED)); // R3

  AST_RED_TO_GREEN: assert property (@(posedge clk) disable iff (!rstN)
    (wrDat && compState == COMP_RED) |=> (compState == COMP_GREEN) && $stable(curIdx)); // R4

  AST_GREEN_TO_BLUE: assert property (@(posedge clk) disable iff (!rstN)
    (wrDat && compState == COMP_GREEN) |=> (compState == COMP_BLUE) && $stable(curIdx)); // R4

  AST_BLUE_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (wrDat && compState == COMP_BLUE) |=>
      (compState == COMP_RED) && (curIdx == IDX_W'($past(curIdx) + 1'b1))); // R5

  AST_IGNORED_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    wrOther |=> $stable(curIdx) && $stable(compState)); // R7

  AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |=> $stable(curIdx) && $stable(compState)); // R6

  AST_IDLE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> $stable(curIdx) && $stable(compState)); // R8
endmodule

bind palette_dac palette_dac_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busValid  (busValid),
  .busWrite  (busWrite),
  .busAddr   (busAddr),
  .busWData  (busWData),
  .curIdx    (curIdx),
  .compState (compState)
);

// File: tb/sim_palette_dac.sv
`timescale 1ns/1ps
module sim_palette_dac;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [31:0] busAddr = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic [7:0]  lookupIdx = '0;
  logic [23:0] lookupColor;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #5 clk = ~clk;

  palette_dac u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData),
    .lookupIdx(lookupIdx), .lookupColor(lookupColor)
  );

  // {addr[11:0], value[7:0], probe[7:0], expected colour[23:0]}
  localparam int NVEC = 18;
  localparam logic [51:0] VECS [NVEC] = '{
    {12'h000, 8'h10, 8'h10, 24'h000000},  // R3 select entry 0x10
    {12'h004, 8'hAA, 8'h10, 24'hAA0000},  // R4 red
    {12'h004, 8'hBB, 8'h10, 24'hAABB00},  // R4 green
    {12'h004, 8'hCC, 8'h10, 24'hAABBCC},  // R4 blue
    {12'h004, 8'h11, 8'h11, 24'h110000},  // R5 advanced to 0x11
    {12'h008, 8'h55, 8'h11, 24'h110000},  // R7 offset 2 ignored
    {12'h00C, 8'h66, 8'h11, 24'h110000},  // R7 offset 3 ignored
    {12'h004, 8'h22, 8'h11, 24'h112200},  // R7 step untouched
    {12'h000, 8'h11, 8'h11, 24'h112200},  // R10 reselect midway
    {12'h004, 8'h33, 8'h11, 24'h332200},  // R10 restarts at red
    {12'h000, 8'hFF, 8'hFF, 24'hFFFFFF},  // R3 select 255
    {12'h004, 8'h01, 8'hFF, 24'h01FFFF},  // R4
    {12'h004, 8'h02, 8'hFF, 24'h0102FF},  // R4
    {12'h004, 8'h03, 8'hFF, 24'h010203},  // R4
    {12'h004, 8'h44, 8'h00, 24'h440000},  // R5 wrap to 0
    {12'h005, 8'h55, 8'h00, 24'h445500},  // R2 low bits ignored
    {12'h104, 8'h66, 8'h00, 24'h445566},  // R2 high bits ignored
    {12'hF04, 8'h77, 8'h01, 24'h770000}   // R2 and R5
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic busOp(input logic wr, input logic [31:0] addr, input logic [7:0] val);
    @(negedge clk);
    busValid = 1'b1;
    busWrite = wr;
    busAddr  = addr;
    busWData = {val, 24'h5A5A5A};
    @(negedge clk);
    busValid = 1'b0;
    busWrite = 1'b0;
  endtask

  task automatic probe(input string req, input logic [7:0] idx, input logic [23:0] exp);
    lookupIdx = idx;
    #1;
    check(req, {8'h0, lookupColor}, {8'h0, exp});
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

  initial begin
    doReset();
    // R1 reset contents
    probe("R1", 8'h00, 24'h000000);
    probe("R1", 8'h80, 24'h000000);
    probe("R1", 8'hFE, 24'h000000);
    probe("R1", 8'hFF, 24'hFFFFFF);
    // R1 first data write goes to red of entry 0
    busOp(1'b1, 32'h4, 8'h9A);
    probe("R1", 8'h00, 24'h9A0000);

    // Vector walk
    for (int v = 0; v < NVEC; v++) begin
      busOp(1'b1, {20'h0, VECS[v][51:40]}, VECS[v][39:32]);
      probe("R2-R10 vector", VECS[v][31:24], VECS[v][23:0]);
    end

    // R6: reads return zero and do not disturb the step
    busOp(1'b1, 32'h0, 8'h05);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = 32'h4; busWData = 32'hEE000000;
    #1;
    check("R6", busRData, 32'h0);
    busAddr = 32'h0;
    #1;
    check("R6", busRData, 32'h0);
    @(negedge clk);
    busValid = 1'b0;
    busOp(1'b1, 32'h4, 8'h21);
    probe("R6", 8'h05, 24'h210000);

    // R8: idle cycle carrying a write pattern is ignored
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b1; busAddr = 32'h0; busWData = 32'h40000000;
    @(negedge clk);
    busAddr = 32'h4; busWData = 32'hDD000000;
    @(negedge clk);
    busWrite = 1'b0;
    probe("R8", 8'h05, 24'h210000);
    probe("R8", 8'h40, 24'h000000);
    busOp(1'b1, 32'h4, 8'h43);
    probe("R8", 8'h05, 24'h214300);

    // R9: one component changes, visible only after the accepting edge
    @(negedge clk);
    lookupIdx = 8'h05;
    busValid = 1'b1; busWrite = 1'b1; busAddr = 32'h4; busWData = 32'h65000000;
    #1;
    check("R9", {8'h0, lookupColor}, 32'h00214300);
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    #1;
    check("R9", {8'h0, lookupColor}, 32'h00214365);
    probe("R9", 8'h04, 24'h000000);
    probe("R9", 8'h06, 24'h000000);

    // R1 again after a second reset
    doReset();
    probe("R1", 8'h05, 24'h000000);
    probe("R1", 8'h10, 24'h000000);
    probe("R1", 8'hFF, 24'hFFFFFF);
    busOp(1'b1, 32'h4, 8'h7E);
    probe("R1", 8'h00, 24'h7E0000);

    finishRun();
  end
endmodule